// File: doc/BRIEF.md
# Serial Program Loader

This block brings a program image into program memory over an asynchronous serial line and then hands control to it. A receiver, oversampled 16 times per bit, turns the incoming line into bytes. Each good byte is sent back out on the transmit line. A loader state machine builds 24-bit fields from those bytes.

The first field is the number of program words. The second is the load address. Every later field is a program word, written to the next program-memory location. When the last word has been written, the block raises a one-cycle start pulse and presents the entry address, which is the address where loading began.

The oversampling enable comes from outside and pulses once per sixteenth of a bit. The processor core and the memory array are outside the block. After a start pulse the loader stays idle until the next reset.

Top module: `serial_prog_loader`

## Requirements
- R1: The first three good bytes after reset form the 24-bit word count. They arrive low byte first, then the middle byte, then the high byte.
- R2: The next three good bytes form the 24-bit load address, in the same low-middle-high byte order.
- R3: Each following group of three bytes, low byte first, is written as one word with a one-cycle `pm_we` pulse. The first word goes to the load address, and the address rises by one for each later word.
- R4: After the last word, `go` pulses high for exactly one cycle, in the same cycle as the final write. `go_addr` then equals the load address.
- R5: A word count of zero produces no writes. `go` pulses right after the third address byte.
- R6: Every good byte is sent back on `txd` as one frame. The frame is a low start bit, eight data bits LSB first, and a high stop bit, each bit lasting 16 `tick16` pulses. `txd` idles high.
- R7: The receiver looks for a high-to-low change, then samples again at the 8th enable tick. If the line is high there, the start is false: no byte, no echo and no effect on the loader.
- R8: A byte whose stop bit samples low pulses `frame_err` for one cycle. That byte is not echoed and does not reach the loader.
- R9: Bytes that arrive back to back are all echoed in order. One byte waits in a one-entry buffer while the transmitter is busy.
- R10: Once `go` has pulsed, further received bytes cause no write and no further `go`, but they are still echoed.
- R11: After reset `txd` is high and `pm_we`, `go` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the baud rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line (echo) |
| pm_addr | output | 24 | Program-memory write address |
| pm_data | output | 24 | Program-memory write data |
| pm_we | output | 1 | Program-memory write strobe |
| go | output | 1 | One-cycle start pulse |
| go_addr | output | 24 | Entry address for the start pulse |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The assertions assume three things about the inputs. `tick16` pulses steadily. Every bit on `rxd` lasts 16 ticks. Bytes arrive no faster than one frame time apart, so the one-entry echo buffer never has to hold two bytes. The bench holds `tick16` at one pulse every four clocks and drives each bit for exactly 64 clocks. It sends frames back to back with no gap, and it lets the echo of one program drain before it resets the block for the next.

// File: rtl/serial_prog_loader.sv
module serial_prog_loader #(
  parameter int W     = 24,
  parameter int DBITS = 8,
  parameter int OSR   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         rxd,
  output logic         txd,
  output logic [W-1:0] pm_addr,
  output logic [W-1:0] pm_data,
  output logic         pm_we,
  output logic         go,
  output logic [W-1:0] go_addr,
  output logic         frame_err
);
  localparam int BPW = W / DBITS;
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DBITS);
  localparam int NW  = $clog2(DBITS + 2);
  localparam int SW  = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
  rx_st_t           rx_st;
  logic [1:0]       rx_sync;
  logic             rx_prev, rx_done;
  logic [CW-1:0]    rx_cnt;
  logic [BW-1:0]    rx_bit;
  logic [DBITS-1:0] rx_sh;
  wire              rx_in = rx_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; rx_prev <= 1'b1; rx_st <= RX_IDLE;
      rx_cnt <= '0; rx_bit <= '0; rx_sh <= '0;
      rx_done <= 1'b0; frame_err <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      rx_done <= 1'b0;
      frame_err <= 1'b0;
      if (tick16) begin
        rx_prev <= rx_in;
        case (rx_st)
          RX_IDLE:  if (rx_prev && !rx_in) begin rx_st <= RX_START; rx_cnt <= '0; end
          RX_START: if (rx_cnt == MID) begin
                      rx_cnt <= '0; rx_bit <= '0;
                      rx_st <= rx_in ? RX_IDLE : RX_DATA;
                    end else rx_cnt <= rx_cnt + CW'(1);
          RX_DATA:  if (rx_cnt == LAST) begin
                      rx_cnt <= '0;
                      rx_sh  <= {rx_in, rx_sh[DBITS-1:1]};
                      rx_bit <= rx_bit + BW'(1);
                      if (rx_bit == BW'(DBITS - 1)) rx_st <= RX_STOP;
                    end else rx_cnt <= rx_cnt + CW'(1);
          RX_STOP:  if (rx_cnt == LAST) begin
                      rx_cnt <= '0; rx_st <= RX_IDLE;
                      if (rx_in) rx_done <= 1'b1; else frame_err <= 1'b1;
                    end else rx_cnt <= rx_cnt + CW'(1);
          default:  rx_st <= RX_IDLE;
        endcase
      end
    end
  end

  // R8
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rx_done && frame_err));

  // echo transmitter with one-entry hold buffer
  logic             hold_v, tx_busy;
  logic [DBITS-1:0] hold_b;
  logic [DBITS+1:0] tx_sh;
  logic [CW-1:0]    tx_cnt;
  logic [NW-1:0]    tx_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_b <= '0; tx_busy <= 1'b0;
      tx_sh <= '1; tx_cnt <= '0; tx_n <= '0;
    end else begin
      if (!tx_busy && hold_v) begin
        tx_sh <= {1'b1, hold_b, 1'b0};
        tx_busy <= 1'b1; tx_cnt <= '0; tx_n <= '0;
        hold_v <= 1'b0;
      end else if (tx_busy && tick16) begin
        if (tx_cnt == LAST) begin
          tx_cnt <= '0;
          tx_sh  <= {1'b1, tx_sh[DBITS+1:1]};
          if (tx_n == NW'(DBITS + 1)) tx_busy <= 1'b0;
          else tx_n <= tx_n + NW'(1);
        end else tx_cnt <= tx_cnt + CW'(1);
      end
      if (rx_done) begin hold_v <= 1'b1; hold_b <= rx_sh; end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // R6
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> !txd);

  // loader
  typedef enum logic [1:0] {L_CNT, L_ADR, L_DAT, L_RUN} ld_t;
  ld_t          ld;
  logic [SW-1:0] bsel;
  logic [W-1:0] acc, remain, waddr, base;
  wire  [W-1:0] field = {rx_sh, acc[W-1:DBITS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld <= L_CNT; bsel <= '0; acc <= '0; remain <= '0; waddr <= '0; base <= '0;
      pm_addr <= '0; pm_data <= '0; pm_we <= 1'b0; go <= 1'b0;
    end else begin
      pm_we <= 1'b0;
      go <= 1'b0;
      if (rx_done && ld != L_RUN) begin
        acc <= field;
        if (bsel == SW'(BPW - 1)) begin
          bsel <= '0;
          case (ld)
            L_CNT: begin remain <= field; ld <= L_ADR; end
            L_ADR: begin
              base <= field; waddr <= field;
              if (remain == '0) begin go <= 1'b1; ld <= L_RUN; end
              else ld <= L_DAT;
            end
            L_DAT: begin
              pm_we <= 1'b1; pm_addr <= waddr; pm_data <= field;
              waddr <= waddr + W'(1);
              remain <= remain - W'(1);
              if (remain == W'(1)) begin go <= 1'b1; ld <= L_RUN; end
            end
            default: ;
          endcase
        end else bsel <= bsel + SW'(1);
      end
    end
  end

  assign go_addr = base;

  // R3
  we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) pm_we |-> $past(ld) == L_DAT);
  // R4
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);
  // R10
  run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (ld == L_RUN) |=> (!pm_we && !go));
endmodule

// File: tb/serial_prog_loader_test.sv
`timescale 1ns/1ps
module serial_prog_loader_test;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic txd, pm_we, go, frame_err;
  logic [23:0] pm_addr, pm_data, go_addr;

  serial_prog_loader uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .txd(txd),
    .pm_addr(pm_addr), .pm_data(pm_data), .pm_we(pm_we),
    .go(go), .go_addr(go_addr), .frame_err(frame_err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  logic [7:0]  sent [0:255];
  logic [7:0]  echo [0:255];
  logic [23:0] exp_data [0:63];
  logic [23:0] exp_base, go_a;
  int sent_n, echo_n, wr_n, go_n, go_at_wr, fe_n;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [23:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  always @(negedge clk) begin
    if (rst_n && pm_we) begin
      chk(pm_data == exp_data[wr_n], "R3 word data", pm_data, exp_data[wr_n]);
      chk(pm_addr == exp_base + 24'(wr_n), "R2 R3 write address", pm_addr, exp_base + 24'(wr_n));
      wr_n++;
    end
    if (rst_n && go) begin go_n++; go_a = go_addr; go_at_wr = wr_n; end
    if (rst_n && frame_err) fe_n++;
  end

  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (64) @(negedge clk);
          b[i] = txd;
        end
        repeat (64) @(negedge clk);
        if (echo_n < 256) echo[echo_n] = b;
        echo_n++;
      end
    end
  end

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(stop);
    rxd = 1'b1;
    if (stop) begin sent[sent_n] = v; sent_n++; end
  endtask

  task automatic run_prog(input int n, input logic [23:0] base, input int extra, input bit inject);
    rst_n = 1'b0;
    rxd = 1'b1;
    repeat (5) @(negedge clk);
    sent_n = 0; echo_n = 0; wr_n = 0; go_n = 0; go_at_wr = -1; fe_n = 0; go_a = '0;
    exp_base = base;
    chk(txd === 1'b1, "R11 txd idle", txd, 1);
    chk(pm_we === 1'b0 && go === 1'b0 && frame_err === 1'b0, "R11 strobes low",
        {pm_we, go, frame_err}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    if (inject) begin
      rxd = 1'b0;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      repeat (300) @(negedge clk);
      chk(echo_n == 0 && fe_n == 0, "R7 false start ignored", echo_n, 0);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b0);
      rxd = 1'b1;
      repeat (300) @(negedge clk);
      chk(fe_n == 1, "R8 frame error pulse", fe_n, 1);
      chk(echo_n == 0, "R8 bad byte not echoed", echo_n, 0);
    end
    for (int i = 0; i < n; i++) exp_data[i] = 24'($urandom);
    for (int k = 0; k < 3; k++) send_byte(byte_of(24'(n), k), 1'b1);
    for (int k = 0; k < 3; k++) send_byte(byte_of(base, k), 1'b1);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 3; k++) send_byte(byte_of(exp_data[i], k), 1'b1);
    for (int i = 0; i < extra; i++) send_byte(8'($urandom), 1'b1);
    repeat (900) @(negedge clk);
    chk(wr_n == n, "R1 R10 write count", wr_n, n);
    chk(go_n == 1, n == 0 ? "R5 single go" : "R4 single go", go_n, 1);
    chk(go_a == base, "R4 go address", go_a, base);
    chk(go_at_wr == n, n == 0 ? "R5 go with no writes" : "R4 go with last write", go_at_wr, n);
    chk(echo_n == sent_n, "R6 R9 echo count", echo_n, sent_n);
    for (int i = 0; i < sent_n && i < echo_n; i++)
      chk(echo[i] == sent[i], "R6 R9 echo byte", echo[i], sent[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    run_prog(6, 24'hA1B2C3, 0, 1'b1);
    run_prog(0, 24'h3C5A7E, 0, 1'b0);
    run_prog(1, 24'hFFFFFF, 3, 1'b0);
    run_prog(12, 24'(($urandom % 24'hFFF000)), 0, 1'b0);
    run_prog(int'($urandom % 6) + 2, 24'h010203, 2, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule